// File: doc/BRIEF.md
# Windowed Majority Filter for a Comparator Bit

This block cleans up a single noisy comparator decision bit. The raw bit is sampled at a programmable, prescaled rate into a sliding window that holds the most recent samples. At each sample the block counts how many ones the window now holds. The filtered output is driven high once the ones reach a programmable threshold and driven low once the zeros reach that same threshold. In every other case it keeps its last value, so a burst of noise shorter than the threshold cannot flip it.

A restart (the chip reset or the filter-clear input) captures the sample divider, the window length and the threshold. It also fills the whole window with a chosen starting level and forces the output to that level. Software or a neighbouring block pulses the clear input after each decision to begin a fresh measurement. Because the window keeps filling after a trip, the restart is the only way to begin counting again from a known state. A one-cycle trip pulse marks every low-to-high change of the filtered output, and it can serve directly as an event or interrupt source.

Top module: `cmp_vote_filter`

## Requirements
- R1: On a cycle with `rst` or `flt_clr` high, the next edge sets `filt_out` to `init_val` and `trip` to 0. The whole window is filled with `init_val`, so no trip pulse appears even when `init_val` is 1.
- R2: After a restart edge, samples of `raw_in` are taken at the (P+1)-th edge and then at every (P+1)-th edge after that, where P is the captured `presc`. A P of 0 takes a sample on every edge.
- R3: At a sample edge, `filt_out` becomes 1 when the number of ones among the last W samples (W = captured `win_len`) is at least T (T = captured `thresh`). Samples older than W have no influence.
- R4: At a sample edge, `filt_out` becomes 0 when the number of zeros among the last W samples is at least T.
- R5: `filt_out` holds its value on every edge that is not a sample edge, and on sample edges where neither count reaches T.
- R6: With a window filled with the opposite level, a constant new input level changes `filt_out` at the T-th sample of that level, which is edge (P+1)*T after the restart edge (for example 10 samples with W=12 and T=10).
- R7: `trip` is high for exactly one cycle, in the cycle where `filt_out` has just changed from 0 to 1 on a sample edge, and is low otherwise.
- R8: `presc`, `win_len`, `thresh` and `init_val` are read only on restart edges. Changing them at any other time has no effect on `filt_out` or `trip`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also a restart |
| flt_clr | input | 1 | Synchronous filter clear (restart) |
| raw_in | input | 1 | Raw comparator bit, synchronous to `clk` |
| presc | input | 16 | Sample divider: one sample every presc+1 clocks |
| win_len | input | 6 | Window length W, 1 to 32 |
| thresh | input | 6 | Vote threshold T, W/2 < T <= W |
| init_val | input | 1 | Level loaded into the window and the output on restart |
| filt_out | output | 1 | Filtered comparator bit |
| trip | output | 1 | One-cycle pulse on each rise of `filt_out` |

## Verification
The assertions assume a legal configuration at every restart: a window of 1 to 32 samples and a threshold strictly above half the window and no larger than it. Only under that condition are the ones-threshold and zeros-threshold conditions mutually exclusive, so that each forces the output. They also assume `raw_in` is already synchronous to `clk`. The stimulus draws its configurations only from that legal range and includes the extremes: a one-sample window, a full 32-sample window, a threshold equal to the window, and a threshold of one more than half the window. During the phase that scrambles the configuration inputs without a restart, it also keeps those inputs within the legal range, so that a late capture would show up as an output mismatch and not as an assertion built on a false premise.

// File: rtl/cvf_pkg.sv
package cvf_pkg;

    localparam int unsigned MAX_WIN = 32;
    localparam int unsigned PRESC_W = 16;
    localparam int unsigned CNT_W   = $clog2(MAX_WIN + 1);

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [CNT_W-1:0]   win;
        logic [CNT_W-1:0]   thr;
    } cfg_t;

    typedef enum logic [1:0] {
        VOTE_HOLD = 2'd0,
        VOTE_HIGH = 2'd1,
        VOTE_LOW  = 2'd2
    } vote_e;

    function automatic vote_e decide(input logic [CNT_W-1:0] ones,
                                     input logic [CNT_W-1:0] win,
                                     input logic [CNT_W-1:0] thr);
        if (ones >= thr)
            return VOTE_HIGH;
        else if ((win - ones) >= thr)
            return VOTE_LOW;
        else
            return VOTE_HOLD;
    endfunction

endpackage

// File: rtl/cvf_prescale.sv
module cvf_prescale #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (restart)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cvf_window.sv
module cvf_window #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          restart,
    input  logic          fill,
    input  logic [CW-1:0] len_load,
    input  logic [CW-1:0] len_cur,
    input  logic          shift_en,
    input  logic          din,
    output logic [CW-1:0] ones_q,
    output logic [CW-1:0] ones_nx
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] sh_q;
    logic [IW-1:0]    old_idx;
    logic             oldest;

    assign old_idx = IW'(len_cur - CW'(1));
    assign oldest  = sh_q[old_idx];
    assign ones_nx = ones_q + CW'(din) - CW'(oldest);

    always_ff @(posedge clk) begin
        if (restart) begin
            sh_q   <= {DEPTH{fill}};
            ones_q <= fill ? len_load : '0;
        end else if (shift_en) begin
            ones_q <= ones_nx;
            if (DEPTH > 1)
                sh_q <= {sh_q[DEPTH-2:0], din};
            else
                sh_q <= din;
        end
    end
endmodule

// File: rtl/cvf_vote.sv
module cvf_vote
    import cvf_pkg::*;
(
    input  logic             clk,
    input  logic             restart,
    input  logic             init,
    input  logic             sample,
    input  logic [CNT_W-1:0] ones_nx,
    input  logic [CNT_W-1:0] win,
    input  logic [CNT_W-1:0] thr,
    output logic             filt_q,
    output logic             trip_q
);
    vote_e verdict;
    logic  filt_d;

    always_comb begin
        verdict = decide(ones_nx, win, thr);
        filt_d  = filt_q;
        if (sample) begin
            case (verdict)
                VOTE_HIGH: filt_d = 1'b1;
                VOTE_LOW:  filt_d = 1'b0;
                default:   filt_d = filt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            filt_q <= init;
            trip_q <= 1'b0;
        end else begin
            filt_q <= filt_d;
            trip_q <= filt_d & ~filt_q;
        end
    end
endmodule

// File: rtl/cmp_vote_filter.sv
module cmp_vote_filter
    import cvf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flt_clr,
    input  logic               raw_in,
    input  logic [PRESC_W-1:0] presc,
    input  logic [CNT_W-1:0]   win_len,
    input  logic [CNT_W-1:0]   thresh,
    input  logic               init_val,
    output logic               filt_out,
    output logic               trip
);
    logic             restart;
    cfg_t             cfg_q;
    logic             tick;
    logic [CNT_W-1:0] ones_q;
    logic [CNT_W-1:0] ones_nx;

    assign restart = rst | flt_clr;

    always_ff @(posedge clk) begin
        if (restart) begin
            cfg_q.presc <= presc;
            cfg_q.win   <= win_len;
            cfg_q.thr   <= thresh;
        end
    end

    cvf_prescale #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .restart (restart),
        .div     (cfg_q.presc),
        .tick    (tick)
    );

    cvf_window #(.DEPTH(MAX_WIN), .CW(CNT_W)) u_win (
        .clk      (clk),
        .restart  (restart),
        .fill     (init_val),
        .len_load (win_len),
        .len_cur  (cfg_q.win),
        .shift_en (tick),
        .din      (raw_in),
        .ones_q   (ones_q),
        .ones_nx  (ones_nx)
    );

    cvf_vote u_vote (
        .clk     (clk),
        .restart (restart),
        .init    (init_val),
        .sample  (tick),
        .ones_nx (ones_nx),
        .win     (cfg_q.win),
        .thr     (cfg_q.thr),
        .filt_q  (filt_out),
        .trip_q  (trip)
    );
endmodule

// File: rtl/cvf_checker.sv
module cvf_checker
    import cvf_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               clr,
    input logic               tick,
    input logic [PRESC_W-1:0] presc,
    input logic [CNT_W-1:0]   ones,
    input logic [CNT_W-1:0]   win,
    input logic [CNT_W-1:0]   thr,
    input logic               filt,
    input logic               trip
);
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst || clr)
        ones <= win);

    a_r3_high_when_ones: assert property (@(posedge clk) disable iff (rst || clr)
        (ones >= thr) |-> filt);

    a_r4_low_when_zeros: assert property (@(posedge clk) disable iff (rst || clr)
        ((win - ones) >= thr) |-> !filt);

    a_r5_hold_off_sample: assert property (@(posedge clk) disable iff (rst || clr)
        !tick |=> $stable(filt));

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst || clr)
        (tick && presc != '0) |=> !tick);

    a_r7_trip_on_rise: assert property (@(posedge clk) disable iff (rst || clr)
        trip |-> (filt && !$past(filt)));

    a_r7_rise_gives_trip: assert property (@(posedge clk) disable iff (rst || clr)
        ($rose(filt) && !$past(rst || clr)) |-> trip);
endmodule

bind cmp_vote_filter cvf_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .clr   (flt_clr),
    .tick  (tick),
    .presc (cfg_q.presc),
    .ones  (ones_q),
    .win   (cfg_q.win),
    .thr   (cfg_q.thr),
    .filt  (filt_out),
    .trip  (trip)
);

// File: tb/cmp_vote_filter_tb.sv
module cmp_vote_filter_tb;
    import cvf_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               flt_clr = 1'b0;
    logic               raw_in = 1'b0;
    logic [PRESC_W-1:0] presc = '0;
    logic [CNT_W-1:0]   win_len = 6'd12;
    logic [CNT_W-1:0]   thresh = 6'd10;
    logic               init_val = 1'b0;
    logic               filt_out;
    logic               trip;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_vote_filter u_dut (
        .clk(clk), .rst(rst), .flt_clr(flt_clr), .raw_in(raw_in),
        .presc(presc), .win_len(win_len), .thresh(thresh),
        .init_val(init_val), .filt_out(filt_out), .trip(trip)
    );

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference
    int m_pc, m_presc, m_win, m_thr;
    bit m_out, m_trip;
    bit m_q[$];

    task automatic check(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst || flt_clr) begin
            m_presc = int'(presc);
            m_win   = int'(win_len);
            m_thr   = int'(thresh);
            m_q.delete();
            for (int i = 0; i < m_win; i++) m_q.push_back(init_val);
            m_out  = init_val;
            m_trip = 0;
            m_pc   = 0;
        end else begin
            bit samp;
            samp   = (m_pc == m_presc);
            m_pc   = samp ? 0 : m_pc + 1;
            m_trip = 0;
            if (samp) begin
                int ones;
                bit nxt;
                m_q.push_back(raw_in);
                void'(m_q.pop_front());
                ones = 0;
                foreach (m_q[i]) ones += m_q[i];
                nxt = m_out;
                if (ones >= m_thr) nxt = 1;
                else if (m_win - ones >= m_thr) nxt = 0;
                m_trip = nxt && !m_out;
                m_out  = nxt;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(cur_req, int'(filt_out), int'(m_out), "filt_out");
            check(cur_req, int'(trip), int'(m_trip), "trip");
        end
    end

    task automatic restart(int p, int w, int t, bit iv);
        @(negedge clk);
        presc = PRESC_W'(p); win_len = CNT_W'(w); thresh = CNT_W'(t); init_val = iv;
        flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0;
    endtask

    task automatic measure(bit v, int exp, string req);
        int n = 0;
        raw_in = v;
        while (filt_out != v && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(req, n, exp, "edges to change");
    endtask

    task automatic noise(int cycles, bit scramble);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if ($urandom % 4 == 0) raw_in = ~raw_in;
            if (scramble) begin
                int w;
                w = 1 + int'($urandom % 32);
                presc    = PRESC_W'($urandom % 3);
                win_len  = CNT_W'(w);
                thresh   = CNT_W'(w / 2 + 1);
                init_val = 1'($urandom);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(filt_out), 0, "reset filt_out");
        check("R1", int'(trip), 0, "reset trip");

        cur_req = "R6";
        measure(1'b1, 10, "R6");
        cur_req = "R7";
        noise(4, 0);

        cur_req = "R3";
        restart(0, 12, 10, 0);
        noise(400, 0);
        cur_req = "R4";
        restart(1, 7, 4, 1);
        noise(400, 0);

        cur_req = "R1";
        restart(3, 5, 3, 1);
        check("R1", int'(filt_out), 1, "clear loads init");
        check("R7", int'(trip), 0, "no trip on clear");
        cur_req = "R2";
        measure(1'b0, 12, "R2");

        cur_req = "R5";
        restart(2, 9, 6, 0);
        noise(600, 0);

        cur_req = "R8";
        restart(1, 8, 5, 0);
        noise(500, 1);

        cur_req = "R3";
        restart(0, 1, 1, 0);
        noise(200, 0);
        cur_req = "R4";
        restart(0, 32, 17, 1);
        noise(800, 0);
        restart(0, 32, 32, 0);
        cur_req = "R6";
        measure(1'b1, 32, "R6");

        cur_req = "R7";
        restart(4, 6, 4, 0);
        noise(600, 0);

        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule